// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM that accepts reads and writes in any order, one per clock, with no idle cycle between a write and a following read. On every qualified rising edge it registers the address, the operation, the byte-lane mask and the decoded chip select. A read is flow-through: its data appears in the same cycle in which its address was registered. A write is split in two. The address is taken at one qualified edge, and the data is taken at the next qualified edge into a pending-write register. That pending entry is committed to the array when the following write brings in its own data.

The data bus is split into `wdata` and `rdata`, and `rvalid` marks the cycles in which the model would drive the bus. A clock-enable input freezes every register, so a cycle can be stretched for as long as needed without deselecting the device. Reads that hit the pending address are served from the pending register, lane by lane, so the array never returns stale data. The memory interface is a plain synchronous port and not a stream: there is no back-pressure. The only way to hold the pipeline is to raise `clk_en_n`.

Top module: `ssram_zt_flow`

## Requirements
- R1: While `rst_n` is low and after its release, before any qualified edge, `rvalid` is 0, `rdata` is 0 and no write is pending.
- R2: A rising edge with `clk_en_n` high is ignored: `rvalid`, `rdata` and all internal state keep their values, and the write data presented in that cycle is not taken.
- R3: The device is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0 at a qualified edge. A deselected edge performs no read and no write, and `rvalid` is 0 in the following cycle.
- R4: At a selected qualified edge with `wr_n`=1, `rvalid` goes to 1 in the cycle after that edge, and `rdata` carries the current contents of `addr`.
- R5: At a selected qualified edge with `wr_n`=0, only the address and the lane mask are taken. The 36-bit data for that write is taken from `wdata` at the next qualified edge, with any stalled edges in between skipped.
- R6: `lane_wr_n[i]`=0 writes bits [9*i+8:9*i] of the word. Lanes whose bit is 1 keep their previous contents.
- R7: A read issued at the qualified edge directly after a write's data edge, to the same address, returns the newly written lanes merged with the older lanes. No idle cycle is needed.
- R8: A write with `lane_wr_n`=4'b1111 leaves the addressed word unchanged.
- R9: `rdata` is 0 in every cycle in which `rvalid` is 0.
- R10: Any mix of reads, writes, deselects and stalls on consecutive edges gives read data equal to a memory that applies each write at its data edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock qualifier, active low; high stretches the current cycle |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write, 1 = read |
| lane_wr_n | input | 4 | Per-lane write select, active low, lane i = bits 9i+8..9i |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, taken one qualified edge after its address |
| rdata | output | 36 | Read data, valid while rvalid is 1, else 0 |
| rvalid | output | 1 | Read data present (bus-drive flag) |

## Verification
Two things can land on the same cycle here. A write's data capture, together with the commit of the older pending entry, can coincide with a read of that same address registered at the same edge. The bench provokes this with write-then-read pairs on a small address set, including partial lane masks and stalls inserted between a write's address and data phases. A behavioural memory in the bench applies each write at its data edge. Its expected `rdata`/`rvalid` are compared with the design on every clock.

// File: rtl/ssram_zt_pkg.sv
package ssram_zt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ssram_ctl_stage.sv
module ssram_ctl_stage
  import ssram_zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              cs_c_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  mask_q
);
  logic sel_ok;
  assign sel_ok = !cs_a_n && cs_b && !cs_c_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      mask_q <= '0;
    end else if (adv) begin
      if (!sel_ok)   op_q <= OP_IDLE;
      else if (wr_n) op_q <= OP_READ;
      else           op_q <= OP_WRITE;
      addr_q <= addr;
      mask_q <= ~lane_wr_n;
    end
  end

  // R3: a deselected qualified edge starts no access
  p_deselect_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sel_ok) |=> (op_q == OP_IDLE));
endmodule

// File: rtl/ssram_write_registry.sv
module ssram_write_registry
  import ssram_zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  op_e               op_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [LANES-1:0]  mask_q,
  input  logic [DATA_W-1:0] wdata,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [LANES-1:0]  commit_mask,
  output logic [DATA_W-1:0] commit_data,
  output logic [LANES-1:0]  hit_mask
);
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_mask;
  logic [DATA_W-1:0] pend_data;
  logic              data_phase;

  assign data_phase = adv && (op_q == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_mask <= '0;
      pend_data <= '0;
    end else if (data_phase) begin
      pend_vld  <= 1'b1;
      pend_addr <= addr_q;
      pend_mask <= mask_q;
      pend_data <= wdata;
    end
  end

  // the older entry retires into the array at the edge a newer one arrives
  assign commit_en   = data_phase && pend_vld;
  assign commit_addr = pend_addr;
  assign commit_mask = pend_mask;
  assign commit_data = pend_data;

  // coherency: lanes the pending entry owns for the address being read
  assign hit_mask = (pend_vld && (pend_addr == addr_q)) ? pend_mask : '0;

  // R5: a data edge always leaves a pending entry behind
  p_data_edge_pends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |=> pend_vld);

  // R1: nothing is pending straight out of reset
  p_reset_empty_r1: assert property (@(posedge clk)
    !rst_n |-> !pend_vld);
endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wmask,
  input  logic [DATA_W-1:0] wword,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wmask[l]) mem[waddr][l*LANE_W +: LANE_W] <= wword[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/ssram_zt_flow.sv
module ssram_zt_flow
  import ssram_zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              cs_c_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_mask;
  logic [DATA_W-1:0] commit_data;
  logic [LANES-1:0]  hit_mask;
  logic [DATA_W-1:0] arr_word;
  logic [DATA_W-1:0] merged;
  logic              adv;

  assign adv = !clk_en_n;

  ssram_ctl_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) ctl_i (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .op_q(op_q), .addr_q(addr_q), .mask_q(mask_q)
  );

  ssram_write_registry #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) reg_i (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .op_q(op_q), .addr_q(addr_q), .mask_q(mask_q), .wdata(wdata),
    .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_mask(commit_mask), .commit_data(commit_data),
    .hit_mask(hit_mask)
  );

  ssram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) arr_i (
    .clk(clk), .we(commit_en), .waddr(commit_addr), .wmask(commit_mask),
    .wword(commit_data), .raddr(addr_q), .rword(arr_word)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = hit_mask[g] ? commit_data[g*LANE_W +: LANE_W]
                                                    : arr_word[g*LANE_W +: LANE_W];
  end

  assign rvalid = (op_q == OP_READ);
  assign rdata  = rvalid ? merged : '0;

  // R2: a stalled edge changes nothing visible
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rvalid) && $stable(rdata)));

  // R4: read data only appears after a selected, qualified read request
  p_rvalid_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $past(!clk_en_n && !cs_a_n && cs_b && !cs_c_n && wr_n));

  // R9: idle bus carries zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rvalid) |-> (rdata == '0));
endmodule

// File: tb/ssram_zt_flow_tb_top.sv
module ssram_zt_flow_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en_n, cs_a_n, cs_b, cs_c_n, wr_n;
  logic [3:0]  lane_wr_n;
  logic [7:0]  addr;
  logic [35:0] wdata;
  logic [35:0] rdata;
  logic        rvalid;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // behavioural reference
  logic [35:0] ref_mem [256];
  bit          ph_w;
  logic [7:0]  ph_a;
  logic [3:0]  ph_m;
  bit          exp_v;
  logic [35:0] exp_d;

  always #10 clk = ~clk;

  ssram_zt_flow dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic compare(input string tag);
    n_vec++;
    if (rvalid !== exp_v || rdata !== exp_d) begin
      n_fail++;
      $display("FAIL %s: got rvalid=%0b rdata=%h, expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, exp_v, exp_d);
    end
  endtask

  task automatic step(input logic s_n, input logic a_n, input logic b,
                      input logic c_n, input logic w_n, input logic [3:0] ln,
                      input logic [7:0] ad, input logic [35:0] d, input string tag);
    @(negedge clk);
    clk_en_n = s_n; cs_a_n = a_n; cs_b = b; cs_c_n = c_n;
    wr_n = w_n; lane_wr_n = ln; addr = ad; wdata = d;
    @(posedge clk);
    if (!s_n) begin
      if (ph_w) begin
        for (int l = 0; l < 4; l++)
          if (ph_m[l]) ref_mem[ph_a][l*9 +: 9] = d[l*9 +: 9];
      end
      ph_w = 0; exp_v = 0; exp_d = '0;
      if (!a_n && b && !c_n) begin
        if (w_n) begin
          exp_v = 1; exp_d = ref_mem[ad];
        end else begin
          ph_w = 1; ph_a = ad; ph_m = ~ln;
        end
      end
    end
    #5;
    compare(tag);
  endtask

  function automatic logic [35:0] rnd36();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[35:0];
  endfunction

  task automatic wr(input logic [7:0] ad, input logic [3:0] ln, input logic [35:0] d, input string tag);
    step(0, 0, 1, 0, 0, ln, ad, d, tag);
  endtask
  task automatic rd(input logic [7:0] ad, input logic [35:0] d, input string tag);
    step(0, 0, 1, 0, 1, 4'hF, ad, d, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [35:0] d0;
    ph_w = 0; exp_v = 0; exp_d = '0;
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    rst_n = 0; clk_en_n = 1; cs_a_n = 1; cs_b = 0; cs_c_n = 1;
    wr_n = 1; lane_wr_n = 4'hF; addr = '0; wdata = '0;
    #45;
    compare("R1");              // during reset
    rst_n = 1;
    #10;
    compare("R1");              // after release, no qualified edge yet

    // fill every word; each step delivers data for the previous address
    for (int i = 0; i < 256; i++) wr(8'(i), 4'h0, rnd36(), "R5");
    rd(8'd0, rnd36(), "R5");
    for (int i = 0; i < 8; i++) rd(8'(i * 37), '0, "R4");

    // R3: each chip select alone deselects; a write attempt must not land
    d0 = 36'h123456789;
    step(0, 1, 1, 0, 0, 4'h0, 8'd5, '0, "R3");
    rd(8'd5, d0, "R3");
    step(0, 0, 0, 0, 0, 4'h0, 8'd5, '0, "R3");
    rd(8'd5, d0, "R3");
    step(0, 0, 1, 1, 0, 4'h0, 8'd5, '0, "R3");
    rd(8'd5, d0, "R3");
    step(0, 0, 1, 1, 1, 4'hF, 8'd5, '0, "R3");   // deselected read: idle bus, R9
    step(0, 1, 0, 1, 1, 4'hF, 8'd6, '0, "R9");

    // R6 / R7: partial lanes, read right after the data edge
    wr(8'd9, 4'b1010, '0, "R6");
    rd(8'd9, 36'hABCDEF012, "R7");
    rd(8'd9, '0, "R6");
    wr(8'd9, 4'b0101, '0, "R6");
    wr(8'd9, 4'b1110, 36'h111111111, "R7");    // second write same word
    rd(8'd9, 36'h222222222, "R7");
    rd(8'd9, '0, "R6");

    // R8: empty mask leaves the word intact
    wr(8'd10, 4'hF, '0, "R8");
    rd(8'd10, 36'hFFFFFFFFF, "R8");

    // R2: stall between address and data phase; stalled data ignored
    wr(8'd12, 4'h0, '0, "R2");
    step(1, 1, 0, 1, 1, 4'hF, 8'd0, 36'h0DEADBEEF, "R2");
    step(1, 0, 1, 0, 0, 4'h0, 8'd3, 36'h0CAFEF00D, "R2");
    rd(8'd12, 36'h876543210, "R2");
    step(1, 0, 1, 0, 0, 4'h0, 8'd20, '0, "R2");  // stall while read shown
    step(1, 1, 1, 1, 0, 4'h0, 8'd21, '0, "R2");
    rd(8'd12, '0, "R2");

    // R10: random mix on a small address window
    for (int k = 0; k < 6000; k++) begin
      int r;
      r = $urandom_range(99);
      step((r < 15) ? 1'b1 : 1'b0,
           ($urandom_range(19) == 0) ? 1'b1 : 1'b0, 1'b1, 1'b0,
           ($urandom_range(1) == 0) ? 1'b1 : 1'b0,
           4'($urandom_range(15)), 8'($urandom_range(7)), rnd36(), "R10");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule